// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

The allocator sits between instruction decode and the issue queues. Each cycle it is offered up to five decoded internal operations in program order. Each operation carries a class code. The allocator packs the operations into one dispatch group of five slots. Slots 1 to 4 are ordinary slots, and slot 5 is reserved for a branch. For every operation it accepts, the allocator reports the slots it takes and the execution pipe it is steered to. Slots are handed out in strict program order, so the free slots always form a run at the top of the ordinary range.

Acceptance uses a per-operation valid/ready handshake that is evaluated in the same cycle. The accepted operations always form a prefix of the offered ones. The first operation that does not fit, or the first invalid one, closes the group. The producer offers the stalled operation again as operation 0 in the following cycle. The slot masks and pipe selects of the accepted operations are registered and appear one cycle after acceptance.

Top module: `dgrp_alloc`

## Requirements
- R1: Accepted operations form a prefix of the offered ones. Acceptance stops at the first operation that is not valid or does not fit in the free slots. Slots are assigned in ascending program order with no overlap. Slot mask bit k stands for slot k+1.
- R2: A branch (class 7) occupies only slot 5 (mask 10000) and is steered to pipe code 4 (branch unit). It is accepted while any slot position is still open, and it closes the group, so no later operation of that cycle is accepted.
- R3: A load (class 4) or store (class 5) takes the next free ordinary slot. It is steered to load/store pipe 1 (code 2) from slot 1 or 4, and to load/store pipe 2 (code 3) from slot 2 or 3.
- R4: A two-way cracked op (class 1) and a load/store with update (class 6) take two adjacent ordinary slots: 1+2, 2+3 or 3+4. A class-6 op is steered by its first slot as in R3. A three-way cracked op (class 2) takes three consecutive ordinary slots.
- R5: A microcoded op (class 3) is accepted only as the first op of an empty group. It takes mask 01111, is steered to pipe code 2, and closes the group.
- R6: An integer divide (class 8) is accepted only into an empty group. It takes mask 00011, is always steered to integer pipe 2 (code 1), and does not close the group.
- R7: A special-register move (class 9, pipe code 4) and a condition-register op (class 10, pipe code 5) are accepted only into slot 1 (mask 00001).
- R8: A simple op (class 0) takes one ordinary slot. Simple and cracked ops are steered to integer pipe 1 (code 0) when their first slot is 1 or 3, and to integer pipe 2 (code 1) when it is 2 or 4.
- R9: in_ready[i] is asserted in the same cycle exactly for the accepted operations. After the next rising clock edge, out_vld[i] equals that acceptance, and out_slot[i] and out_pipe[i] hold the accepted op's mask and pipe.
- R10: While rst_n is low, no in_ready bit and no out_vld bit is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NOPS | Per-op valid, bit i = op i in program order |
| in_cls | input | NOPS x 4 | Per-op class code |
| in_ready | output | NOPS | Per-op accept, same cycle |
| out_vld | output | NOPS | Registered accept flags |
| out_slot | output | NOPS x 5 | Registered slot mask per op |
| out_pipe | output | NOPS x 3 | Registered pipe select per op |

## Verification
The stimulus consists of fixed groups, each chosen to separate a single decision.
- A run of single-slot loads and stores tells the two load/store pipes apart by slot.
- Paired and triple ops started at each reachable position show where a multi-slot op stops fitting.
- Branches placed first, mid-group and last confirm that the fifth slot is taken and the group closes.
- Microcoded, divide and slot-1-only ops placed behind another op show that they stall.
- An offer with a hole in the valid bits shows that acceptance stops at the hole.
- Reset asserted during a live offer shows that nothing is accepted.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;
  localparam int unsigned SLOT_N = 5;          // four ordinary slots plus branch slot
  localparam int unsigned ORD_N  = SLOT_N - 1;
  localparam int unsigned CLS_W  = 4;
  localparam int unsigned PIPE_W = 3;
  localparam int unsigned POS_W  = $clog2(SLOT_N + 1);

  // slot position encoding: 0..ORD_N-1 next free ordinary slot,
  // ORD_N only the branch slot left, ORD_N+1 group closed
  localparam logic [POS_W-1:0] POS_BR_ONLY = POS_W'(ORD_N);
  localparam logic [POS_W-1:0] POS_CLOSED  = POS_W'(ORD_N + 1);

  typedef enum logic [CLS_W-1:0] {
    C_SIMPLE = 4'd0,
    C_CRACK2 = 4'd1,
    C_CRACK3 = 4'd2,
    C_MICRO  = 4'd3,
    C_LOAD   = 4'd4,
    C_STORE  = 4'd5,
    C_LSUPD  = 4'd6,
    C_BRANCH = 4'd7,
    C_DIVIDE = 4'd8,
    C_SPRMOV = 4'd9,
    C_CRLOG  = 4'd10
  } op_cls_e;

  typedef enum logic [PIPE_W-1:0] {
    P_INT1 = 3'd0,
    P_INT2 = 3'd1,
    P_LS1  = 3'd2,
    P_LS2  = 3'd3,
    P_BRU  = 3'd4,
    P_CRU  = 3'd5
  } pipe_e;
endpackage

// File: rtl/dgrp_place.sv
module dgrp_place
  import dgrp_pkg::*;
(
  input  logic [POS_W-1:0]  pos_i,
  input  logic [CLS_W-1:0]  cls_i,
  output logic              fit_o,
  output logic [SLOT_N-1:0] mask_o,
  output logic [PIPE_W-1:0] pipe_o,
  output logic [POS_W-1:0]  pos_o
);
  localparam logic [SLOT_N-1:0] ONE_SLOT = SLOT_N'(1);
  localparam logic [SLOT_N-1:0] TWO_SLOT = SLOT_N'(3);
  localparam logic [SLOT_N-1:0] TRI_SLOT = SLOT_N'(7);
  localparam logic [SLOT_N-1:0] ALL_ORD  = SLOT_N'((1 << ORD_N) - 1);
  localparam logic [SLOT_N-1:0] BR_SLOT  = SLOT_N'(1 << ORD_N);

  logic room1, room2, room3, empty, open;
  logic [PIPE_W-1:0] ls_pipe, int_pipe;

  always_comb begin
    room1 = (pos_i < POS_W'(ORD_N));
    room2 = (pos_i < POS_W'(ORD_N - 1));
    room3 = (pos_i < POS_W'(ORD_N - 2));
    empty = (pos_i == '0);
    open  = (pos_i != POS_CLOSED);
    // load/store steering by first slot: outer slots pipe 1, inner slots pipe 2
    ls_pipe  = (pos_i == '0 || pos_i == POS_W'(ORD_N - 1)) ? P_LS1 : P_LS2;
    int_pipe = pos_i[0] ? P_INT2 : P_INT1;
  end

  always_comb begin
    fit_o  = 1'b0;
    mask_o = '0;
    pipe_o = int_pipe;
    pos_o  = pos_i;
    case (cls_i)
      C_CRACK2: begin
        fit_o  = room2;
        mask_o = TWO_SLOT << pos_i;
        pos_o  = pos_i + POS_W'(2);
      end
      C_LSUPD: begin
        fit_o  = room2;
        mask_o = TWO_SLOT << pos_i;
        pipe_o = ls_pipe;
        pos_o  = pos_i + POS_W'(2);
      end
      C_CRACK3: begin
        fit_o  = room3;
        mask_o = TRI_SLOT << pos_i;
        pos_o  = pos_i + POS_W'(3);
      end
      C_MICRO: begin
        fit_o  = empty;
        mask_o = ALL_ORD;
        pipe_o = P_LS1;
        pos_o  = POS_CLOSED;
      end
      C_LOAD, C_STORE: begin
        fit_o  = room1;
        mask_o = ONE_SLOT << pos_i;
        pipe_o = ls_pipe;
        pos_o  = pos_i + POS_W'(1);
      end
      C_BRANCH: begin
        fit_o  = open;
        mask_o = BR_SLOT;
        pipe_o = P_BRU;
        pos_o  = POS_CLOSED;
      end
      C_DIVIDE: begin
        fit_o  = empty;
        mask_o = TWO_SLOT;
        pipe_o = P_INT2;
        pos_o  = POS_W'(2);
      end
      C_SPRMOV: begin
        fit_o  = empty;
        mask_o = ONE_SLOT;
        pipe_o = P_BRU;
        pos_o  = POS_W'(1);
      end
      C_CRLOG: begin
        fit_o  = empty;
        mask_o = ONE_SLOT;
        pipe_o = P_CRU;
        pos_o  = POS_W'(1);
      end
      default: begin  // simple and unassigned codes
        fit_o  = room1;
        mask_o = ONE_SLOT << pos_i;
        pos_o  = pos_i + POS_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/dgrp_outreg.sv
module dgrp_outreg
  import dgrp_pkg::*;
#(
  parameter int unsigned NOPS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NOPS-1:0]               acc_i,
  input  logic [NOPS-1:0][SLOT_N-1:0]   mask_i,
  input  logic [NOPS-1:0][PIPE_W-1:0]   pipe_i,
  output logic [NOPS-1:0]               vld_o,
  output logic [NOPS-1:0][SLOT_N-1:0]   mask_o,
  output logic [NOPS-1:0][PIPE_W-1:0]   pipe_o
);
  logic [NOPS-1:0]             vld_d;
  logic [NOPS-1:0][SLOT_N-1:0] mask_d;
  logic [NOPS-1:0][PIPE_W-1:0] pipe_d;

  always_comb begin
    vld_d = acc_i;
    for (int i = 0; i < NOPS; i++) begin
      mask_d[i] = acc_i[i] ? mask_i[i] : mask_o[i];   // load enable per op
      pipe_d[i] = acc_i[i] ? pipe_i[i] : pipe_o[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= '0;
      mask_o <= '0;
      pipe_o <= '0;
    end else begin
      vld_o  <= vld_d;
      mask_o <= mask_d;
      pipe_o <= pipe_d;
    end
  end
endmodule

// File: rtl/dgrp_alloc.sv
module dgrp_alloc
  import dgrp_pkg::*;
#(
  parameter int unsigned NOPS = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NOPS-1:0]             in_valid,
  input  logic [NOPS-1:0][CLS_W-1:0]  in_cls,
  output logic [NOPS-1:0]             in_ready,
  output logic [NOPS-1:0]             out_vld,
  output logic [NOPS-1:0][SLOT_N-1:0] out_slot,
  output logic [NOPS-1:0][PIPE_W-1:0] out_pipe
);
  logic [NOPS:0]                 go;
  logic [NOPS:0][POS_W-1:0]      pos;
  logic [NOPS-1:0]               fit;
  logic [NOPS-1:0]               acc;
  logic [NOPS-1:0][SLOT_N-1:0]   mask;
  logic [NOPS-1:0][PIPE_W-1:0]   pipe;
  logic [NOPS-1:0][POS_W-1:0]    npos;

  assign go[0]  = rst_n;
  assign pos[0] = '0;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    dgrp_place u_place (
      .pos_i  (pos[g]),
      .cls_i  (in_cls[g]),
      .fit_o  (fit[g]),
      .mask_o (mask[g]),
      .pipe_o (pipe[g]),
      .pos_o  (npos[g])
    );
    assign acc[g]    = go[g] & in_valid[g] & fit[g];
    assign go[g+1]   = acc[g];
    assign pos[g+1]  = acc[g] ? npos[g] : POS_CLOSED;
  end

  assign in_ready = acc;

  dgrp_outreg #(.NOPS(NOPS)) u_outreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_i  (acc),
    .mask_i (mask),
    .pipe_i (pipe),
    .vld_o  (out_vld),
    .mask_o (out_slot),
    .pipe_o (out_pipe)
  );
endmodule

// File: rtl/dgrp_chk.sv
module dgrp_chk
  import dgrp_pkg::*;
#(
  parameter int unsigned NOPS = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NOPS-1:0]             in_valid,
  input logic [NOPS-1:0][CLS_W-1:0]  in_cls,
  input logic [NOPS-1:0]             in_ready,
  input logic [NOPS-1:0]             out_vld,
  input logic [NOPS-1:0][SLOT_N-1:0] out_slot,
  input logic [NOPS-1:0][PIPE_W-1:0] out_pipe
);
  a_r10_no_ready_in_reset: assert property (@(posedge clk)
    !rst_n |-> (in_ready == '0));

  for (genvar g = 0; g < NOPS; g++) begin : g_chk
    a_r9_accept_registered: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_ready[g]) |=> out_vld[g]);
    a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[g] && in_ready[g]) |=> !out_vld[g]);
    a_r2_branch_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[g] && out_slot[g][SLOT_N-1]) |->
        (out_slot[g] == SLOT_N'(1 << ORD_N) && out_pipe[g] == P_BRU));
    a_r3_ls_steer: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[g] && $countones(out_slot[g]) == 1 &&
       (out_pipe[g] == P_LS1 || out_pipe[g] == P_LS2)) |->
        (out_pipe[g] == ((out_slot[g][0] || out_slot[g][ORD_N-1]) ? P_LS1 : P_LS2)));
    a_r6_divide: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_ready[g] && in_cls[g] == C_DIVIDE) |=>
        (out_slot[g] == SLOT_N'(3) && out_pipe[g] == P_INT2));
    a_r5_micro_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_ready[g] && in_cls[g] == C_MICRO) |=>
        (out_slot[g] == SLOT_N'((1 << ORD_N) - 1) && out_pipe[g] == P_LS1));
    if (g > 0) begin : g_pair
      a_r1_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld[g] |-> out_vld[g-1]);
      a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld[g] |-> ((out_slot[g] & out_slot[g-1]) == '0 && out_slot[g] > out_slot[g-1]));
      a_r5_micro_first: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid[g] && in_ready[g] && in_cls[g] == C_MICRO));
      a_r2_branch_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[g-1] && in_ready[g-1] && in_cls[g-1] == C_BRANCH) |-> !in_ready[g]);
    end
  end
endmodule

bind dgrp_alloc dgrp_chk #(.NOPS(NOPS)) u_dgrp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_cls   (in_cls),
  .in_ready (in_ready),
  .out_vld  (out_vld),
  .out_slot (out_slot),
  .out_pipe (out_pipe)
);

// File: tb/test_dgrp_alloc.sv
module test_dgrp_alloc;
  import dgrp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk;
  logic rst_n;
  logic [N-1:0]             in_valid;
  logic [N-1:0][CLS_W-1:0]  in_cls;
  logic [N-1:0]             in_ready;
  logic [N-1:0]             out_vld;
  logic [N-1:0][SLOT_N-1:0] out_slot;
  logic [N-1:0][PIPE_W-1:0] out_pipe;

  dgrp_alloc #(.NOPS(N)) i_dgrp_alloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_ready(in_ready), .out_vld(out_vld), .out_slot(out_slot), .out_pipe(out_pipe)
  );

  typedef struct {
    logic [N-1:0] vld;
    logic [SLOT_N-1:0] m [N];
    logic [PIPE_W-1:0] p [N];
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [CLS_W-1:0]  c [N];
  logic [SLOT_N-1:0] m [N];
  logic [PIPE_W-1:0] p [N];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one offer, checks the handshake, queues the registered result
  task automatic offer(input logic [N-1:0] vld, input logic [N-1:0] rdy, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = vld;
    for (int i = 0; i < N; i++) in_cls[i] = c[i];
    #1;
    chk(in_ready == rdy, tag, "in_ready", int'(in_ready), int'(rdy));
    e.vld = rdy;
    for (int i = 0; i < N; i++) begin
      e.m[i] = m[i];
      e.p[i] = p[i];
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares registered outputs a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_vld == e.vld, e.tag, "out_vld", int'(out_vld), int'(e.vld));
        for (int i = 0; i < N; i++) begin
          if (e.vld[i]) begin
            chk(out_slot[i] == e.m[i], e.tag, $sformatf("out_slot[%0d]", i),
                int'(out_slot[i]), int'(e.m[i]));
            chk(out_pipe[i] == e.p[i], e.tag, $sformatf("out_pipe[%0d]", i),
                int'(out_pipe[i]), int'(e.p[i]));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = '0;
    in_cls   = '0;
    for (int i = 0; i < N; i++) begin c[i] = C_SIMPLE; m[i] = '0; p[i] = '0; end
    repeat (2) @(negedge clk);
    in_valid = '1;
    #1;
    chk(in_ready == '0, "R10", "in_ready in reset", int'(in_ready), 0);
    chk(out_vld == '0, "R10", "out_vld in reset", int'(out_vld), 0);
    @(negedge clk);
    in_valid = '0;
    rst_n = 1'b1;

    // R3 R1: single-slot loads/stores, steering by slot, branch last
    c = '{C_LOAD, C_LOAD, C_STORE, C_LOAD, C_BRANCH};
    m = '{5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000};
    p = '{P_LS1, P_LS2, P_LS2, P_LS1, P_BRU};
    offer(5'b11111, 5'b11111, "R3");

    // R1: fifth load/store does not fit
    c = '{C_LOAD, C_LOAD, C_LOAD, C_LOAD, C_STORE};
    m = '{5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b00000};
    p = '{P_LS1, P_LS2, P_LS2, P_LS1, P_INT1};
    offer(5'b11111, 5'b01111, "R1");

    // R2: branch after one op closes the group
    c = '{C_SIMPLE, C_BRANCH, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b10000, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_BRU, P_INT1, P_INT1, P_INT1};
    offer(5'b00111, 5'b00011, "R2");

    // R2: branch first
    c = '{C_BRANCH, C_SIMPLE, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b10000, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_BRU, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00001, "R2");

    // R4: cracked pair then update pair at 3+4, next op stalls
    c = '{C_CRACK2, C_LSUPD, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00011, 5'b01100, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_LS2, P_INT1, P_INT1, P_INT1};
    offer(5'b00111, 5'b00011, "R4");

    // R9: stalled op reoffered first; update pair 2+3, second pair cannot take 4+5
    c = '{C_SIMPLE, C_LSUPD, C_LSUPD, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b00110, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_LS2, P_INT1, P_INT1, P_INT1};
    offer(5'b00111, 5'b00011, "R9");

    // R4 R3: update pair 1+2 goes to load/store pipe 1
    c = '{C_LSUPD, C_STORE, C_LOAD, C_BRANCH, C_SIMPLE};
    m = '{5'b00011, 5'b00100, 5'b01000, 5'b10000, 5'b0};
    p = '{P_LS1, P_LS2, P_LS1, P_BRU, P_INT1};
    offer(5'b01111, 5'b01111, "R4");

    // R4 R8: three-way crack from slot 1, simple in slot 4
    c = '{C_CRACK3, C_SIMPLE, C_BRANCH, C_SIMPLE, C_SIMPLE};
    m = '{5'b00111, 5'b01000, 5'b10000, 5'b0, 5'b0};
    p = '{P_INT1, P_INT2, P_BRU, P_INT1, P_INT1};
    offer(5'b00111, 5'b00111, "R8");

    // R4: three-way crack from slot 2, then from slot 3 does not fit
    c = '{C_SIMPLE, C_CRACK3, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b01110, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_INT2, P_INT1, P_INT1, P_INT1};
    offer(5'b00111, 5'b00011, "R4");
    c = '{C_SIMPLE, C_SIMPLE, C_CRACK3, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b00010, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_INT2, P_INT1, P_INT1, P_INT1};
    offer(5'b00111, 5'b00011, "R4");

    // R5: microcoded op alone, and stalled behind another op
    c = '{C_MICRO, C_SIMPLE, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b01111, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_LS1, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00001, "R5");
    c = '{C_SIMPLE, C_MICRO, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00001, "R5");

    // R6 R8: divide in slots 1+2, group stays open
    c = '{C_DIVIDE, C_SIMPLE, C_SIMPLE, C_BRANCH, C_SIMPLE};
    m = '{5'b00011, 5'b00100, 5'b01000, 5'b10000, 5'b0};
    p = '{P_INT2, P_INT1, P_INT2, P_BRU, P_INT1};
    offer(5'b01111, 5'b01111, "R6");
    c = '{C_SIMPLE, C_DIVIDE, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00001, "R6");

    // R7: slot-1-only ops
    c = '{C_SPRMOV, C_CRLOG, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_BRU, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00001, "R7");
    c = '{C_CRLOG, C_SIMPLE, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b00010, 5'b0, 5'b0, 5'b0};
    p = '{P_CRU, P_INT2, P_INT1, P_INT1, P_INT1};
    offer(5'b00011, 5'b00011, "R7");

    // R1: hole in the valid bits ends acceptance
    c = '{C_SIMPLE, C_SIMPLE, C_SIMPLE, C_SIMPLE, C_SIMPLE};
    m = '{5'b00001, 5'b0, 5'b0, 5'b0, 5'b0};
    p = '{P_INT1, P_INT1, P_INT1, P_INT1, P_INT1};
    offer(5'b10101, 5'b00001, "R1");

    // R9: idle cycle shows nothing
    offer(5'b00000, 5'b00000, "R9");

    // R10: reset during a live offer
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 5'b11111;
    #1;
    chk(in_ready == '0, "R10", "in_ready under reset", int'(in_ready), 0);
    chk(out_vld == '0, "R10", "out_vld under reset", int'(out_vld), 0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(out_vld == '0, "R10", "out_vld after edge in reset", int'(out_vld), 0);
    @(negedge clk);
    in_valid = '0;
    rst_n = 1'b1;

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule